// File: doc/BRIEF.md
# Store Queue with Load Dependence Resolution

This block keeps the stores that are in flight in program order and answers, for each load, whether memory may be read or whether an older store decides the value. Stores are allocated one at a time at the queue tail. The block hands back the tail pointer, which carries a wrap bit. The issuing logic uses its low bits as the slot index when the store's address and data later arrive, each on its own write port and in either order. The store at the head goes out on the memory store port once both fields are known, and it leaves the queue when memory accepts it.

A load copies the tail pointer when it issues. Every store allocated before that copy, and still in the queue, is older than the load. When the load later presents a word-aligned address, the block scans those older stores from youngest to oldest. One cycle later it reports one of four outcomes: read memory, take a forwarded value, wait for a named producer, or stall. A mode input chooses how a store with an unknown address is treated. In conservative mode it blocks the load. In speculative mode the load passes it, predicting that the two do not depend on each other.

Each slot runs a five-state machine. The states are `SLOT_EMPTY`, `SLOT_WAIT_BOTH`, `SLOT_HAVE_ADDR`, `SLOT_HAVE_DATA` and `SLOT_READY`, and the transitions are:

- EMPTY to WAIT_BOTH on allocation.
- WAIT_BOTH to HAVE_ADDR on an address write, to HAVE_DATA on a data write, or to READY when both arrive together.
- HAVE_ADDR to READY on a data write.
- HAVE_DATA to READY on an address write.
- READY to EMPTY on retirement.

Top module: `stq_disamb`

## Requirements
- R1: After reset the queue is empty: `sq_tail_o` is 0, and `sq_full_o`, `mem_st_valid_o` and `rsp_valid_o` are 0.
- R2: An accepted allocation places the store in slot `sq_tail_o[2:0]`, records its producer tag and increments the 4-bit `sq_tail_o`, bit 3 being the wrap bit. With 8 stores held, `sq_full_o` is 1 and a further allocation is ignored, leaving `sq_tail_o` unchanged.
- R3: Address and data are written by slot index, independently and in either order. `mem_st_valid_o` is 1 only when the head store has both fields. It presents that store's address and data, and stores leave in allocation order, one per cycle in which `mem_st_ready_i` is 1.
- R4: A load request gives `rsp_valid_o` = 1 in the next cycle. `rsp_kind_o` is encoded as 0 = memory, 1 = forward, 2 = producer tag, 3 = stall.
- R5: A load considers only the stores allocated before its snapshot `ld_pos_i` that are still queued. Younger stores have no effect on its result.
- R6: When no older store matches the address and none blocks the load, the outcome is memory (0).
- R7: When the youngest older store that decides the outcome matches the address and holds data, the outcome is forward (1) and `rsp_data_o` carries that store's data. When several older stores match, the youngest of them wins.
- R8: When that deciding store matches but has no data yet, the outcome is producer tag (2) and `rsp_tag_o` is the tag recorded at its allocation.
- R9: In conservative mode (`spec_mode_i` = 0), an older store with an unknown address that is younger than every matching older store gives stall (3).
- R10: In speculative mode (`spec_mode_i` = 1), stores with unknown addresses are skipped and stall never occurs. The outcome is decided by the youngest matching older store, or is memory if there is none.
- R11: Age order stays correct when the pointers wrap past slot 7 and past the wrap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spec_mode_i | input | 1 | 1 = speculate past unknown store addresses |
| st_alloc_i | input | 1 | Allocate a store at the tail |
| st_tag_i | input | TAG_W | Producer tag of the store's data |
| sq_tail_o | output | PTR_W | Tail pointer with wrap bit |
| sq_full_o | output | 1 | Queue holds DEPTH stores |
| st_addr_we_i | input | 1 | Address write strobe |
| st_addr_idx_i | input | IDX_W | Slot receiving the address |
| st_addr_i | input | ADDR_W | Store address |
| st_data_we_i | input | 1 | Data write strobe |
| st_data_idx_i | input | IDX_W | Slot receiving the data |
| st_data_i | input | DATA_W | Store data |
| mem_st_valid_o | output | 1 | Head store ready for memory |
| mem_st_ready_i | input | 1 | Memory accepts the head store |
| mem_st_addr_o | output | ADDR_W | Head store address |
| mem_st_data_o | output | DATA_W | Head store data |
| ld_req_i | input | 1 | Load lookup request |
| ld_pos_i | input | PTR_W | Tail snapshot taken at load issue |
| ld_addr_i | input | ADDR_W | Load address |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_kind_o | output | 2 | Lookup outcome code |
| rsp_data_o | output | DATA_W | Forwarded store data |
| rsp_tag_o | output | TAG_W | Producer tag to wait on |

## Verification
The assertions take for granted that address and data writes target only slots that are allocated, and only while the field being written is still unknown. They also assume a load's snapshot is never older than the current head. The stimulus guarantees this by deriving every write index and snapshot from the tail pointer the block returns, and by draining the queue only after every pending field has been filled. Within those limits the bench sweeps every mix of four slot states over every snapshot depth and both modes, so the head moves through every wrap position.

// File: rtl/stq_pkg.sv
package stq_pkg;
    typedef enum logic [2:0] {
        SLOT_EMPTY,
        SLOT_WAIT_BOTH,
        SLOT_HAVE_ADDR,
        SLOT_HAVE_DATA,
        SLOT_READY
    } slot_state_e;

    typedef enum logic [1:0] {
        LD_TO_MEM   = 2'd0,
        LD_FORWARD  = 2'd1,
        LD_PRODUCER = 2'd2,
        LD_STALL    = 2'd3
    } ld_outcome_e;
endpackage

// File: rtl/stq_slot.sv
module stq_slot
    import stq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              addr_we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_we_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              retire_i,
    output logic              busy_o,
    output logic              addr_known_o,
    output logic              data_known_o,
    output logic              ready_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [TAG_W-1:0]  tag_o
);
    slot_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY:     if (alloc_i) state_d = SLOT_WAIT_BOTH;
            SLOT_WAIT_BOTH: begin
                if (addr_we_i && data_we_i) state_d = SLOT_READY;
                else if (addr_we_i)         state_d = SLOT_HAVE_ADDR;
                else if (data_we_i)         state_d = SLOT_HAVE_DATA;
            end
            SLOT_HAVE_ADDR: if (data_we_i) state_d = SLOT_READY;
            SLOT_HAVE_DATA: if (addr_we_i) state_d = SLOT_READY;
            SLOT_READY:     if (retire_i)  state_d = SLOT_EMPTY;
            default:        state_d = SLOT_EMPTY;
        endcase
    end

    always_comb begin
        busy_o       = 1'b1;
        addr_known_o = 1'b0;
        data_known_o = 1'b0;
        ready_o      = 1'b0;
        unique case (state_q)
            SLOT_EMPTY:     busy_o = 1'b0;
            SLOT_WAIT_BOTH: ;
            SLOT_HAVE_ADDR: addr_known_o = 1'b1;
            SLOT_HAVE_DATA: data_known_o = 1'b1;
            SLOT_READY: begin
                addr_known_o = 1'b1;
                data_known_o = 1'b1;
                ready_o      = 1'b1;
            end
            default:        busy_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            data_o <= '0;
            tag_o  <= '0;
        end else begin
            if (alloc_i && !busy_o)                    tag_o  <= tag_i;
            if (addr_we_i && busy_o && !addr_known_o)  addr_o <= addr_i;
            if (data_we_i && busy_o && !data_known_o)  data_o <= data_i;
        end
    end
endmodule

// File: rtl/stq_ptrs.sv
module stq_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req_i,
    input  logic             retire_i,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] tail_o,
    output logic [PTR_W-1:0] count_o,
    output logic             full_o,
    output logic             alloc_fire_o
);
    always_comb begin
        count_o      = tail_o - head_o;
        full_o       = (count_o == PTR_W'(DEPTH));
        alloc_fire_o = alloc_req_i && !full_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_o <= '0;
            tail_o <= '0;
        end else begin
            if (alloc_fire_o) tail_o <= tail_o + 1'b1;
            if (retire_i)     head_o <= head_o + 1'b1;
        end
    end
endmodule

// File: rtl/stq_lookup.sv
module stq_lookup
    import stq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [DEPTH-1:0]  busy_i,
    input  logic [DEPTH-1:0]  addr_known_i,
    input  logic [DEPTH-1:0]  data_known_i,
    input  logic [ADDR_W-1:0] addr_i [DEPTH],
    input  logic [DATA_W-1:0] data_i [DEPTH],
    input  logic [TAG_W-1:0]  tag_i  [DEPTH],
    input  logic [PTR_W-1:0]  head_i,
    input  logic [PTR_W-1:0]  count_i,
    input  logic [PTR_W-1:0]  ld_pos_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic              spec_i,
    output ld_outcome_e       kind_o,
    output logic [DATA_W-1:0] data_o,
    output logic [TAG_W-1:0]  tag_o
);
    logic [PTR_W-1:0] older_n;
    logic             blk_any, blk_unknown, hit_any;
    logic [IDX_W-1:0] blk_idx, hit_idx, idx;

    // Scan oldest to youngest so that a younger candidate overwrites an older one.
    always_comb begin
        older_n = ld_pos_i - head_i;
        if (older_n > count_i) older_n = '0;
        blk_any     = 1'b0;
        blk_unknown = 1'b0;
        blk_idx     = '0;
        hit_any     = 1'b0;
        hit_idx     = '0;
        idx         = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_i[IDX_W-1:0] + IDX_W'(k);
            if (PTR_W'(k) < older_n && busy_i[idx]) begin
                if (!addr_known_i[idx]) begin
                    blk_any     = 1'b1;
                    blk_unknown = 1'b1;
                    blk_idx     = idx;
                end else if (addr_i[idx] == ld_addr_i) begin
                    blk_any     = 1'b1;
                    blk_unknown = 1'b0;
                    blk_idx     = idx;
                    hit_any     = 1'b1;
                    hit_idx     = idx;
                end
            end
        end
    end

    always_comb begin
        kind_o = LD_TO_MEM;
        data_o = '0;
        tag_o  = '0;
        if (spec_i) begin
            if (hit_any) begin
                kind_o = data_known_i[hit_idx] ? LD_FORWARD : LD_PRODUCER;
                data_o = data_i[hit_idx];
                tag_o  = tag_i[hit_idx];
            end
        end else if (blk_any) begin
            if (blk_unknown) kind_o = LD_STALL;
            else             kind_o = data_known_i[blk_idx] ? LD_FORWARD : LD_PRODUCER;
            data_o = data_i[blk_idx];
            tag_o  = tag_i[blk_idx];
        end
    end
endmodule

// File: rtl/stq_disamb.sv
module stq_disamb
    import stq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_mode_i,
    input  logic              st_alloc_i,
    input  logic [TAG_W-1:0]  st_tag_i,
    output logic [PTR_W-1:0]  sq_tail_o,
    output logic              sq_full_o,
    input  logic              st_addr_we_i,
    input  logic [IDX_W-1:0]  st_addr_idx_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic              st_data_we_i,
    input  logic [IDX_W-1:0]  st_data_idx_i,
    input  logic [DATA_W-1:0] st_data_i,
    output logic              mem_st_valid_o,
    input  logic              mem_st_ready_i,
    output logic [ADDR_W-1:0] mem_st_addr_o,
    output logic [DATA_W-1:0] mem_st_data_o,
    input  logic              ld_req_i,
    input  logic [PTR_W-1:0]  ld_pos_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    output logic              rsp_valid_o,
    output logic [1:0]        rsp_kind_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic [TAG_W-1:0]  rsp_tag_o
);
    logic [PTR_W-1:0]  head_q, tail_q, count_w;
    logic              alloc_fire, retire_w;
    logic [DEPTH-1:0]  s_busy, s_addr_known, s_data_known, s_ready;
    logic [ADDR_W-1:0] s_addr [DEPTH];
    logic [DATA_W-1:0] s_data [DEPTH];
    logic [TAG_W-1:0]  s_tag  [DEPTH];
    ld_outcome_e       lk_kind;
    logic [DATA_W-1:0] lk_data;
    logic [TAG_W-1:0]  lk_tag;
    logic [IDX_W-1:0]  head_idx, tail_idx;

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];

    assign mem_st_valid_o = s_ready[head_idx];
    assign mem_st_addr_o  = s_addr[head_idx];
    assign mem_st_data_o  = s_data[head_idx];
    assign retire_w       = mem_st_valid_o && mem_st_ready_i;
    assign sq_tail_o      = tail_q;

    stq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_req_i  (st_alloc_i),
        .retire_i     (retire_w),
        .head_o       (head_q),
        .tail_o       (tail_q),
        .count_o      (count_w),
        .full_o       (sq_full_o),
        .alloc_fire_o (alloc_fire)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        stq_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (alloc_fire && tail_idx == IDX_W'(i)),
            .tag_i        (st_tag_i),
            .addr_we_i    (st_addr_we_i && st_addr_idx_i == IDX_W'(i)),
            .addr_i       (st_addr_i),
            .data_we_i    (st_data_we_i && st_data_idx_i == IDX_W'(i)),
            .data_i       (st_data_i),
            .retire_i     (retire_w && head_idx == IDX_W'(i)),
            .busy_o       (s_busy[i]),
            .addr_known_o (s_addr_known[i]),
            .data_known_o (s_data_known[i]),
            .ready_o      (s_ready[i]),
            .addr_o       (s_addr[i]),
            .data_o       (s_data[i]),
            .tag_o        (s_tag[i])
        );
    end

    stq_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_lookup (
        .busy_i       (s_busy),
        .addr_known_i (s_addr_known),
        .data_known_i (s_data_known),
        .addr_i       (s_addr),
        .data_i       (s_data),
        .tag_i        (s_tag),
        .head_i       (head_q),
        .count_i      (count_w),
        .ld_pos_i     (ld_pos_i),
        .ld_addr_i    (ld_addr_i),
        .spec_i       (spec_mode_i),
        .kind_o       (lk_kind),
        .data_o       (lk_data),
        .tag_o        (lk_tag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_kind_o  <= 2'd0;
            rsp_data_o  <= '0;
            rsp_tag_o   <= '0;
        end else begin
            rsp_valid_o <= ld_req_i;
            if (ld_req_i) begin
                rsp_kind_o <= lk_kind;
                rsp_data_o <= lk_data;
                rsp_tag_o  <= lk_tag;
            end
        end
    end
endmodule

// File: rtl/stq_disamb_chk.sv
module stq_disamb_chk #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spec_mode_i,
    input logic             st_alloc_i,
    input logic             sq_full_o,
    input logic [PTR_W-1:0] sq_tail_o,
    input logic [PTR_W-1:0] head_q,
    input logic             mem_st_valid_o,
    input logic             mem_st_ready_i,
    input logic             ld_req_i,
    input logic             rsp_valid_o,
    input logic [1:0]       rsp_kind_o
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(sq_tail_o - head_q) <= PTR_W'(DEPTH)); // R2
    AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        st_alloc_i && sq_full_o |=> $stable(sq_tail_o)); // R2
    AST_ALLOC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        st_alloc_i && !sq_full_o |=> sq_tail_o == PTR_W'($past(sq_tail_o) + 1'b1)); // R2
    AST_RETIRE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_st_valid_o && mem_st_ready_i |=> head_q == PTR_W'($past(head_q) + 1'b1)); // R3
    AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_st_valid_o |=> $stable(head_q)); // R3
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req_i |=> rsp_valid_o); // R4
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req_i |=> !rsp_valid_o); // R4
    AST_EMPTY_TO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req_i && sq_tail_o == head_q |=> rsp_kind_o == 2'd0); // R6
    AST_SPEC_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req_i && spec_mode_i |=> rsp_kind_o != 2'd3); // R10
endmodule

bind stq_disamb stq_disamb_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .spec_mode_i    (spec_mode_i),
    .st_alloc_i     (st_alloc_i),
    .sq_full_o      (sq_full_o),
    .sq_tail_o      (sq_tail_o),
    .head_q         (head_q),
    .mem_st_valid_o (mem_st_valid_o),
    .mem_st_ready_i (mem_st_ready_i),
    .ld_req_i       (ld_req_i),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_kind_o     (rsp_kind_o)
);

// File: tb/stq_disamb_bench.sv
`timescale 1ns/1ps
module stq_disamb_bench;
    localparam int DEPTH = 8, ADDR_W = 16, DATA_W = 16, TAG_W = 4;
    localparam int IDX_W = 3, PTR_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spec_mode_i = 0, st_alloc_i = 0, st_addr_we_i = 0, st_data_we_i = 0;
    logic mem_st_ready_i = 0, ld_req_i = 0;
    logic [TAG_W-1:0]  st_tag_i = '0;
    logic [IDX_W-1:0]  st_addr_idx_i = '0, st_data_idx_i = '0;
    logic [ADDR_W-1:0] st_addr_i = '0, ld_addr_i = '0;
    logic [DATA_W-1:0] st_data_i = '0;
    logic [PTR_W-1:0]  ld_pos_i = '0;
    logic [PTR_W-1:0]  sq_tail_o;
    logic              sq_full_o, mem_st_valid_o, rsp_valid_o;
    logic [ADDR_W-1:0] mem_st_addr_o;
    logic [DATA_W-1:0] mem_st_data_o, rsp_data_o;
    logic [1:0]        rsp_kind_o;
    logic [TAG_W-1:0]  rsp_tag_o;

    int checks = 0, fails = 0;
    int opt [4];
    logic [DATA_W-1:0] sdat [4];
    logic [TAG_W-1:0]  stag [4];
    logic [ADDR_W-1:0] exp_addr [8];
    logic [DATA_W-1:0] exp_data [8];
    logic [PTR_W-1:0]  base;

    always #4 clk = ~clk;

    stq_disamb u_stq_disamb (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic alloc(input logic [TAG_W-1:0] t);
        st_alloc_i = 1; st_tag_i = t;
        tick();
        st_alloc_i = 0;
    endtask

    task automatic wr(input bit is_addr, input logic [IDX_W-1:0] i, input logic [15:0] v);
        if (is_addr) begin st_addr_we_i = 1; st_addr_idx_i = i; st_addr_i = v; end
        else         begin st_data_we_i = 1; st_data_idx_i = i; st_data_i = v; end
        tick();
        st_addr_we_i = 0; st_data_we_i = 0;
    endtask

    task automatic load(input logic [PTR_W-1:0] pos, input logic [ADDR_W-1:0] a, input bit sp,
                        input int ek, input logic [DATA_W-1:0] ed, input logic [TAG_W-1:0] et, input string req);
        ld_req_i = 1; ld_pos_i = pos; ld_addr_i = a; spec_mode_i = sp;
        tick();
        ld_req_i = 0;
        chk("R4", "rsp_valid", 32'(rsp_valid_o), 1);
        chk(req, "rsp_kind", 32'(rsp_kind_o), 32'(ek));
        if (ek == 1) chk(req, "rsp_data", 32'(rsp_data_o), 32'(ed));
        if (ek == 2) chk(req, "rsp_tag", 32'(rsp_tag_o), 32'(et));
    endtask

    task automatic drain(input int n);
        int j = 0;
        mem_st_ready_i = 1;
        for (int g = 0; g < 64 && j < n; g++) begin
            if (mem_st_valid_o) begin
                chk("R3", "mem_st_addr", 32'(mem_st_addr_o), 32'(exp_addr[j]));
                chk("R3", "mem_st_data", 32'(mem_st_data_o), 32'(exp_data[j]));
                j++;
            end
            tick();
        end
        mem_st_ready_i = 0;
        chk("R3", "drained count", 32'(j), 32'(n));
        chk("R3", "valid after drain", 32'(mem_st_valid_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "tail", 32'(sq_tail_o), 0);
        chk("R1", "full", 32'(sq_full_o), 0);
        chk("R1", "mem_valid", 32'(mem_st_valid_o), 0);
        chk("R1", "rsp_valid", 32'(rsp_valid_o), 0);
        load(4'd0, 16'h0200, 0, 0, 0, 0, "R6 empty");

        // R2 fill to capacity, then overflow attempt
        for (int i = 0; i < 8; i++) begin
            chk("R2", "tail before alloc", 32'(sq_tail_o), 32'(i));
            alloc(TAG_W'(i + 3));
        end
        chk("R2", "full", 32'(sq_full_o), 1);
        alloc(4'hF);
        chk("R2", "tail held when full", 32'(sq_tail_o), 8);
        // addresses first: stores 0,3,6 share one word, 1,4,7 another
        for (int i = 0; i < 8; i++) begin
            exp_addr[i] = 16'h0200 + 16'(4 * (i % 3));
            exp_data[i] = 16'h00A0 + 16'(i);
            wr(1, IDX_W'(i), exp_addr[i]);
        end
        chk("R3", "no retire without data", 32'(mem_st_valid_o), 0);
        load(4'd8, 16'h0200, 0, 2, 0, 4'd9, "R8 youngest pending");
        for (int i = 0; i < 8; i++) wr(0, IDX_W'(i), exp_data[i]);
        load(4'd8, 16'h0200, 0, 1, 16'h00A6, 0, "R7 youngest of several");
        load(4'd5, 16'h0200, 0, 1, 16'h00A3, 0, "R7 R5 snapshot limits age");
        load(4'd8, 16'h0300, 1, 0, 0, 0, "R6 no match");
        drain(8);
        chk("R2", "not full after drain", 32'(sq_full_o), 0);

        // Sweep: every mix of four slot states, every depth, both modes, wrapping base
        base = 4'd8;
        for (int c = 0; c < 256; c++) begin
            logic [ADDR_W-1:0] a_m, a_o;
            a_m = 16'h1000 + 16'(c * 8);
            a_o = a_m + 16'd4;
            chk("R11", "tail at combo start", 32'(sq_tail_o), 32'(base));
            for (int k = 0; k < 4; k++) begin
                opt[k]  = (c >> (2 * k)) & 3;
                sdat[k] = 16'(c * 16 + k + 1);
                stag[k] = TAG_W'(c + k);
                alloc(stag[k]);
            end
            // opt: 0 data only, 1 address only (match), 2 match with data, 3 other address with data
            for (int k = 0; k < 4; k++) begin
                logic [IDX_W-1:0] ix;
                ix = IDX_W'(base + PTR_W'(k));
                if (opt[k] != 1) wr(0, ix, sdat[k]);
                if (opt[k] != 0) wr(1, ix, (opt[k] == 3) ? a_o : a_m);
            end
            chk("R3", "head valid only when complete", 32'(mem_st_valid_o), 32'(opt[0] >= 2));
            for (int sp = 0; sp < 2; sp++) begin
                for (int n = 0; n <= 4; n++) begin
                    int ek, sel;
                    string rq;
                    ek = 0; sel = 0;
                    for (int k = 0; k < n; k++) begin
                        if (opt[k] == 0 && sp == 0) ek = 3;
                        if (opt[k] == 1) begin ek = 2; sel = k; end
                        if (opt[k] == 2) begin ek = 1; sel = k; end
                    end
                    rq = (ek == 0) ? "R6" : (ek == 1) ? "R7" : (ek == 2) ? "R8" : "R9";
                    if (sp == 1) rq = {rq, " R10"};
                    rq = {rq, " R5 R11"};
                    load(base + PTR_W'(n), a_m, sp[0], ek, sdat[sel], stag[sel], rq);
                end
            end
            for (int k = 0; k < 4; k++) begin
                logic [IDX_W-1:0] ix;
                ix = IDX_W'(base + PTR_W'(k));
                if (opt[k] == 0) wr(1, ix, a_o);
                if (opt[k] == 1) wr(0, ix, sdat[k]);
                exp_addr[k] = (opt[k] == 0 || opt[k] == 3) ? a_o : a_m;
                exp_data[k] = sdat[k];
            end
            drain(4);
            base = base + 4'd4;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule